// File: doc/BRIEF.md
# Feature ID Register Read Arbiter

This block settles what happens when software tries to read a 32-bit, read-only register that describes the vector and floating-point features of a processor. The processor has four privilege levels, 0 to 3. The block takes the level the read comes from, a request strobe and a write flag. It also takes the trap and enable controls that the higher levels hold. From these it picks exactly one outcome:

- undefined instruction,
- trap to level 2 in its 64-bit form,
- trap to level 2 in its 32-bit hypervisor form,
- trap to level 3,
- a successful read.

A trap outcome also carries an 8-bit syndrome code. A successful read carries the register contents. The contents are fixed at build time by eight 4-bit feature-level parameters, and are checked for legal combinations during elaboration.

The controls are evaluated through a strict priority chain. The chain differs for each privilege level, and the path that fires decides both where the trap goes and which syndrome code is reported. The result is registered and appears one cycle after the request, together with a one-cycle valid pulse.

Top module: `idreg_access_arb`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_vld`, `rsp_kind`, `rsp_code` and `rsp_data` are all zero.
- R2: A request sampled with `req_vld` high at a rising edge produces `rsp_vld` high after that edge, for one cycle per request. While `rsp_vld` is high, exactly one bit of `rsp_kind` is set: bit 0 undefined, bit 1 level-2 64-bit trap, bit 2 level-2 32-bit trap, bit 3 level-3 trap, bit 4 success. While `rsp_vld` is low, `rsp_kind`, `rsp_code` and `rsp_data` are zero.
- R3: When `l1_aa32_ok` is low, every request is undefined, at any level and whatever the other controls are.
- R4: A request from level 0 is always undefined.
- R5: A request with `req_wr` high is always undefined.
- R6: At level 1 the first checks give undefined, ahead of every trap. They fire in two cases:
  - `l3_undef_prio` is set together with an active 64-bit level-3 FP trap. The level-3 FP trap is active when `l3_present` is high, `l3_is32` is low and `l3_fp_trap` is high.
  - `ns_cp_deny` is high, or `l1_cp_acc` equals 2'b00.
- R7: At level 1, the next checks trap to level 2 in 64-bit form with code 0x07. They fire in two cases:
  - `l2_fp_trap` is high while level 2 is enabled, 64-bit and not in host mode.
  - Host mode is active with `l2_host_fp_en0` low.
- R8: At level 1, the next checks trap to level 2 with code 0x08:
  - When level 2 is enabled and 32-bit, `l2_cp_trap` gives the 32-bit form.
  - After that, `l2_id3_trap` with level 2 enabled gives the 32-bit form when `l2_is32` is high, and the 64-bit form otherwise.
- R9: At levels 1 and 2, the last check is the active 64-bit level-3 FP trap. It traps to level 3 with code 0x07, or gives undefined when `l3_undef_ovr` is high.
- R10: At level 2 the chain is:
  - the undefined-priority check of R6;
  - the host-mode check of R7;
  - then, with level 2 enabled, `ns_cp_deny` or `l2_cp_trap` gives the 32-bit level-2 trap with code 0x00;
  - then R9.
  `l2_id3_trap` and `l1_cp_acc` have no effect at level 2.
- R11: At level 3 only `l1_cp_acc` matters: 2'b00 gives undefined, and any other value gives success.
- R12: A successful read returns the register value in `rsp_data` with `rsp_code` 0. The fields are packed, from bit 31 down, as: fused multiply-add, FP half-precision, vector half-precision, vector single-precision, vector integer, vector load/store, NaN propagation, denormal support. Any other outcome returns `rsp_data` 0, and an undefined outcome returns `rsp_code` 0.
- R13: Elaboration rejects an illegal configuration:
  - The (FP half, vector half) pair must be (0,0), (2,1) or (3,2).
  - Vector single-precision may be 1 only when vector integer is 1.
  - Every other field must be 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Access request strobe |
| req_wr | input | 1 | Request is a write |
| cur_lvl | input | 2 | Privilege level of the access |
| l1_aa32_ok | input | 1 | Level 1 can run in 32-bit state |
| l2_en | input | 1 | Level 2 is enabled |
| l2_is32 | input | 1 | Level 2 runs in 32-bit state |
| l2_host | input | 1 | Level 2 is in host mode |
| l3_present | input | 1 | Level 3 is implemented |
| l3_is32 | input | 1 | Level 3 runs in 32-bit state |
| l3_fp_trap | input | 1 | Level-3 FP access trap bit |
| l3_undef_prio | input | 1 | Level-3 undefined-takes-priority flag |
| l3_undef_ovr | input | 1 | Level-3 flag turning its FP trap into undefined |
| ns_cp_deny | input | 1 | Non-secure coprocessor access denied (already qualified by a 32-bit level 3) |
| l1_cp_acc | input | 2 | Level-1 coprocessor access field |
| l2_fp_trap | input | 1 | Level-2 FP trap bit (64-bit level 2) |
| l2_host_fp_en0 | input | 1 | Low bit of the host-mode FP enable field |
| l2_cp_trap | input | 1 | Level-2 coprocessor trap bit (32-bit level 2) |
| l2_id3_trap | input | 1 | Level-2 ID-group-3 trap bit |
| rsp_vld | output | 1 | Outcome valid pulse |
| rsp_kind | output | 5 | One-hot outcome |
| rsp_code | output | 8 | Syndrome code for traps |
| rsp_data | output | 32 | Register value on success |

## Verification
The bench builds the block with the fields set to 1, 2, 1, 0, 1, 1, 0, 1 from the top, so the register reads 0x12101101. This value mixes ones, twos and zeros at known positions, so a field packed at the wrong offset or in the wrong order shows up in `rsp_data`. The half-precision pair (2,1) is the middle legal pair, and a single-precision level of 0 next to an integer level of 1 exercises the dependency rule in its permitted direction. Each scenario raises one control, or two controls that compete, so every link in each level's chain is seen winning and losing against its neighbours.

// File: rtl/idreg_arb_pkg.sv
package idreg_arb_pkg;

  localparam int LVL_W      = 2;
  localparam int CODE_W     = 8;
  localparam int NUM_KINDS  = 5;
  localparam int NUM_FIELDS = 8;

  // Outcome index; also the bit position in the one-hot response
  typedef enum logic [2:0] {
    K_UNDEF    = 3'd0,
    K_TRAP2_64 = 3'd1,
    K_TRAP2_32 = 3'd2,
    K_TRAP3    = 3'd3,
    K_OK       = 3'd4
  } kind_e;

  localparam logic [CODE_W-1:0] SYN_NONE   = 8'h00;
  localparam logic [CODE_W-1:0] SYN_FP     = 8'h07;
  localparam logic [CODE_W-1:0] SYN_IDCP   = 8'h08;
  localparam logic [CODE_W-1:0] SYN_HYP_CP = 8'h00;

  typedef struct packed {
    logic       l1_aa32_ok;
    logic       l2_en;
    logic       l2_is32;
    logic       l2_host;
    logic       l3_present;
    logic       l3_is32;
    logic       l3_fp_trap;
    logic       l3_undef_prio;
    logic       l3_undef_ovr;
    logic       ns_cp_deny;
    logic [1:0] l1_cp_acc;
    logic       l2_fp_trap;
    logic       l2_host_fp_en0;
    logic       l2_cp_trap;
    logic       l2_id3_trap;
  } ctrl_t;

  typedef struct packed {
    kind_e             kind;
    logic [CODE_W-1:0] code;
  } verdict_t;

  function automatic verdict_t mk_verdict(kind_e k, logic [CODE_W-1:0] c);
    verdict_t r;
    r.kind = k;
    r.code = c;
    return r;
  endfunction

endpackage

// File: rtl/idreg_value_pack.sv
module idreg_value_pack
  import idreg_arb_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int unsigned FMA_LVL    = 1,
  parameter int unsigned FPHALF_LVL = 3,
  parameter int unsigned VHALF_LVL  = 2,
  parameter int unsigned VSGL_LVL   = 1,
  parameter int unsigned VINT_LVL   = 1,
  parameter int unsigned VLDST_LVL  = 1,
  parameter int unsigned NANP_LVL   = 1,
  parameter int unsigned DENORM_LVL = 1
) (
  output logic [NUM_FIELDS*FIELD_W-1:0] value
);

  localparam int DATA_W = NUM_FIELDS * FIELD_W;

  // Index 0 is the least significant field
  function automatic int unsigned field_at(int idx);
    case (idx)
      0:       return DENORM_LVL;
      1:       return NANP_LVL;
      2:       return VLDST_LVL;
      3:       return VINT_LVL;
      4:       return VSGL_LVL;
      5:       return VHALF_LVL;
      6:       return FPHALF_LVL;
      default: return FMA_LVL;
    endcase
  endfunction

  localparam bit HP_OK   = (FPHALF_LVL == 0 && VHALF_LVL == 0) ||
                           (FPHALF_LVL == 2 && VHALF_LVL == 1) ||
                           (FPHALF_LVL == 3 && VHALF_LVL == 2);
  localparam bit SP_OK   = (VSGL_LVL == 0) || (VSGL_LVL == 1 && VINT_LVL == 1);
  localparam bit FLAG_OK = (FMA_LVL <= 1) && (VINT_LVL <= 1) && (VLDST_LVL <= 1) &&
                           (NANP_LVL <= 1) && (DENORM_LVL <= 1);

  // R13: configuration legality at elaboration
  if (!HP_OK) begin : g_bad_hp
    $error("idreg_value_pack: half-precision pair (%0d,%0d) is not permitted",
           FPHALF_LVL, VHALF_LVL);
  end
  if (!SP_OK) begin : g_bad_sp
    $error("idreg_value_pack: single-precision level needs integer level 1");
  end
  if (!FLAG_OK) begin : g_bad_flag
    $error("idreg_value_pack: a single-bit feature field exceeds 1");
  end

  logic [DATA_W-1:0] packed_w;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    assign packed_w[gi*FIELD_W +: FIELD_W] = FIELD_W'(field_at(gi));
  end

  assign value = packed_w;

endmodule

// File: rtl/idreg_rule_chain.sv
module idreg_rule_chain
  import idreg_arb_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  logic             wr,
  input  ctrl_t            c,
  output verdict_t         v
);

  logic     l3_fp64;
  logic     undef_first;
  logic     host_fp_off;
  verdict_t l3_last;

  always_comb begin
    l3_fp64     = c.l3_present && !c.l3_is32 && c.l3_fp_trap;
    undef_first = l3_fp64 && c.l3_undef_prio;
    host_fp_off = c.l2_host && !c.l2_host_fp_en0;
    l3_last     = c.l3_undef_ovr ? mk_verdict(K_UNDEF, SYN_NONE)
                                 : mk_verdict(K_TRAP3, SYN_FP);
    v           = mk_verdict(K_OK, SYN_NONE);

    if (wr || !c.l1_aa32_ok) begin
      v = mk_verdict(K_UNDEF, SYN_NONE);
    end else begin
      case (lvl)
        2'd1: begin
          if (undef_first)
            v = mk_verdict(K_UNDEF, SYN_NONE);
          else if (c.ns_cp_deny || c.l1_cp_acc == 2'b00)
            v = mk_verdict(K_UNDEF, SYN_NONE);
          else if (c.l2_en && !c.l2_is32 && !c.l2_host && c.l2_fp_trap)
            v = mk_verdict(K_TRAP2_64, SYN_FP);
          else if (host_fp_off)
            v = mk_verdict(K_TRAP2_64, SYN_FP);
          else if (c.l2_en && c.l2_is32 && (c.ns_cp_deny || c.l2_cp_trap))
            v = mk_verdict(K_TRAP2_32, SYN_IDCP);
          else if (c.l2_en && c.l2_id3_trap)
            v = mk_verdict(c.l2_is32 ? K_TRAP2_32 : K_TRAP2_64, SYN_IDCP);
          else if (l3_fp64)
            v = l3_last;
        end
        2'd2: begin
          if (undef_first)
            v = mk_verdict(K_UNDEF, SYN_NONE);
          else if (host_fp_off)
            v = mk_verdict(K_TRAP2_64, SYN_FP);
          else if (c.l2_en && (c.ns_cp_deny || c.l2_cp_trap))
            v = mk_verdict(K_TRAP2_32, SYN_HYP_CP);
          else if (l3_fp64)
            v = l3_last;
        end
        2'd3: begin
          if (c.l1_cp_acc == 2'b00)
            v = mk_verdict(K_UNDEF, SYN_NONE);
        end
        default: v = mk_verdict(K_UNDEF, SYN_NONE);
      endcase
    end
  end

endmodule

// File: rtl/idreg_outcome_reg.sv
module idreg_outcome_reg
  import idreg_arb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_vld,
  input  verdict_t             v,
  input  logic [DATA_W-1:0]    value,
  output logic                 rsp_vld,
  output logic [NUM_KINDS-1:0] rsp_kind,
  output logic [CODE_W-1:0]    rsp_code,
  output logic [DATA_W-1:0]    rsp_data
);

  logic [NUM_KINDS-1:0] kind_oh;

  always_comb begin
    for (int i = 0; i < NUM_KINDS; i++) begin
      kind_oh[i] = (int'(v.kind) == i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_kind <= '0;
      rsp_code <= '0;
      rsp_data <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_kind <= kind_oh;
        rsp_code <= v.code;
        rsp_data <= (v.kind == K_OK) ? value : '0;
      end else begin
        rsp_kind <= '0;
        rsp_code <= '0;
        rsp_data <= '0;
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld && rsp_kind == '0 && rsp_data == '0);
  // R2
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> $countones(rsp_kind) == 1);
  // R12
  fail_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && !rsp_kind[K_OK]) |-> rsp_data == '0);
  // R12
  plain_no_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_kind[K_OK] || rsp_kind[K_UNDEF]) |-> rsp_code == '0);

endmodule

// File: rtl/idreg_access_arb.sv
module idreg_access_arb
  import idreg_arb_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int unsigned FMA_LVL    = 1,
  parameter int unsigned FPHALF_LVL = 3,
  parameter int unsigned VHALF_LVL  = 2,
  parameter int unsigned VSGL_LVL   = 1,
  parameter int unsigned VINT_LVL   = 1,
  parameter int unsigned VLDST_LVL  = 1,
  parameter int unsigned NANP_LVL   = 1,
  parameter int unsigned DENORM_LVL = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_vld,
  input  logic                          req_wr,
  input  logic [1:0]                    cur_lvl,
  input  logic                          l1_aa32_ok,
  input  logic                          l2_en,
  input  logic                          l2_is32,
  input  logic                          l2_host,
  input  logic                          l3_present,
  input  logic                          l3_is32,
  input  logic                          l3_fp_trap,
  input  logic                          l3_undef_prio,
  input  logic                          l3_undef_ovr,
  input  logic                          ns_cp_deny,
  input  logic [1:0]                    l1_cp_acc,
  input  logic                          l2_fp_trap,
  input  logic                          l2_host_fp_en0,
  input  logic                          l2_cp_trap,
  input  logic                          l2_id3_trap,
  output logic                          rsp_vld,
  output logic [4:0]                    rsp_kind,
  output logic [7:0]                    rsp_code,
  output logic [NUM_FIELDS*FIELD_W-1:0] rsp_data
);

  localparam int DATA_W = NUM_FIELDS * FIELD_W;

  ctrl_t             ctrl;
  verdict_t          verdict;
  logic [DATA_W-1:0] id_value;

  always_comb begin
    ctrl.l1_aa32_ok     = l1_aa32_ok;
    ctrl.l2_en          = l2_en;
    ctrl.l2_is32        = l2_is32;
    ctrl.l2_host        = l2_host;
    ctrl.l3_present     = l3_present;
    ctrl.l3_is32        = l3_is32;
    ctrl.l3_fp_trap     = l3_fp_trap;
    ctrl.l3_undef_prio  = l3_undef_prio;
    ctrl.l3_undef_ovr   = l3_undef_ovr;
    ctrl.ns_cp_deny     = ns_cp_deny;
    ctrl.l1_cp_acc      = l1_cp_acc;
    ctrl.l2_fp_trap     = l2_fp_trap;
    ctrl.l2_host_fp_en0 = l2_host_fp_en0;
    ctrl.l2_cp_trap     = l2_cp_trap;
    ctrl.l2_id3_trap    = l2_id3_trap;
  end

  idreg_value_pack #(
    .FIELD_W   (FIELD_W),
    .FMA_LVL   (FMA_LVL),
    .FPHALF_LVL(FPHALF_LVL),
    .VHALF_LVL (VHALF_LVL),
    .VSGL_LVL  (VSGL_LVL),
    .VINT_LVL  (VINT_LVL),
    .VLDST_LVL (VLDST_LVL),
    .NANP_LVL  (NANP_LVL),
    .DENORM_LVL(DENORM_LVL)
  ) u_value (
    .value(id_value)
  );

  idreg_rule_chain u_chain (
    .lvl(cur_lvl),
    .wr (req_wr),
    .c  (ctrl),
    .v  (verdict)
  );

  idreg_outcome_reg #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .req_vld (req_vld),
    .v       (verdict),
    .value   (id_value),
    .rsp_vld (rsp_vld),
    .rsp_kind(rsp_kind),
    .rsp_code(rsp_code),
    .rsp_data(rsp_data)
  );

  // R3
  no_aa32_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !l1_aa32_ok) |=> rsp_kind == 5'b00001);
  // R4
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && cur_lvl == 2'd0) |=> rsp_kind == 5'b00001);
  // R5
  write_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_wr) |=> rsp_kind == 5'b00001);
  // R11
  lvl3_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && l1_aa32_ok && !req_wr && cur_lvl == 2'd3 && l1_cp_acc != 2'b00)
      |=> rsp_kind == 5'b10000);

endmodule

// File: tb/idreg_access_arb_bench.sv
module idreg_access_arb_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_VAL = 32'h1210_1101;
  localparam int UND = 0, T64 = 1, T32 = 2, T3 = 3, OK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_vld = 1'b0, req_wr = 1'b0;
  logic [1:0] cur_lvl = 2'd1;
  logic l1_aa32_ok, l2_en, l2_is32, l2_host, l3_present, l3_is32;
  logic l3_fp_trap, l3_undef_prio, l3_undef_ovr, ns_cp_deny;
  logic [1:0] l1_cp_acc;
  logic l2_fp_trap, l2_host_fp_en0, l2_cp_trap, l2_id3_trap;
  logic rsp_vld;
  logic [4:0] rsp_kind;
  logic [7:0] rsp_code;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idreg_access_arb #(
    .FIELD_W(4), .FMA_LVL(1), .FPHALF_LVL(2), .VHALF_LVL(1), .VSGL_LVL(0),
    .VINT_LVL(1), .VLDST_LVL(1), .NANP_LVL(0), .DENORM_LVL(1)
  ) u_idreg_access_arb (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .cur_lvl(cur_lvl),
    .l1_aa32_ok(l1_aa32_ok), .l2_en(l2_en), .l2_is32(l2_is32), .l2_host(l2_host),
    .l3_present(l3_present), .l3_is32(l3_is32), .l3_fp_trap(l3_fp_trap),
    .l3_undef_prio(l3_undef_prio), .l3_undef_ovr(l3_undef_ovr),
    .ns_cp_deny(ns_cp_deny), .l1_cp_acc(l1_cp_acc), .l2_fp_trap(l2_fp_trap),
    .l2_host_fp_en0(l2_host_fp_en0), .l2_cp_trap(l2_cp_trap),
    .l2_id3_trap(l2_id3_trap), .rsp_vld(rsp_vld), .rsp_kind(rsp_kind),
    .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  task automatic check(string tag, logic [45:0] act, logic [45:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual vld/kind/code/data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic benign();
    l1_aa32_ok = 1; l2_en = 1; l2_is32 = 0; l2_host = 0; l3_present = 1;
    l3_is32 = 0; l3_fp_trap = 0; l3_undef_prio = 0; l3_undef_ovr = 0;
    ns_cp_deny = 0; l1_cp_acc = 2'b11; l2_fp_trap = 0; l2_host_fp_en0 = 1;
    l2_cp_trap = 0; l2_id3_trap = 0; req_wr = 0;
  endtask

  // Controls are set by the caller before this task; one request, one check
  task automatic access(string tag, logic [1:0] lvl, int kind, logic [7:0] code);
    logic [4:0] ek;
    ek = 5'b00001 << kind;
    @(negedge clk);
    cur_lvl = lvl;
    req_vld = 1;
    @(negedge clk);
    req_vld = 0;
    check(tag, {rsp_vld, rsp_kind, rsp_code, rsp_data},
          {1'b1, ek, code, (kind == OK) ? EXP_VAL : 32'h0});
    benign();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 during reset", {rsp_vld, rsp_kind, rsp_code, rsp_data}, 46'h0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {rsp_vld, rsp_kind, rsp_code, rsp_data}, 46'h0);
  endtask

  task automatic t_timing();
    access("R2 single read", 2'd1, OK, 8'h00);
    @(negedge clk);
    check("R2 pulse ends", {rsp_vld, rsp_kind, rsp_code, rsp_data}, 46'h0);
    @(negedge clk);
    cur_lvl = 2'd3; req_vld = 1;
    @(negedge clk);
    check("R2 back-to-back first", {rsp_vld, rsp_kind}, {1'b1, 5'b10000});
    cur_lvl = 2'd0;
    @(negedge clk);
    req_vld = 0;
    check("R2 back-to-back second", {rsp_vld, rsp_kind}, {1'b1, 5'b00001});
  endtask

  task automatic t_no_aa32();
    for (int l = 0; l < 4; l++) begin
      l1_aa32_ok = 0;
      access("R3 no 32-bit level 1", 2'(l), UND, 8'h00);
    end
  endtask

  task automatic t_lvl0();
    access("R4 level 0", 2'd0, UND, 8'h00);
    l1_cp_acc = 2'b00; l2_id3_trap = 1;
    access("R4 level 0 with traps", 2'd0, UND, 8'h00);
  endtask

  task automatic t_write();
    req_wr = 1;
    access("R5 write at level 3", 2'd3, UND, 8'h00);
    req_wr = 1;
    access("R5 write at level 1", 2'd1, UND, 8'h00);
  endtask

  task automatic t_l1_undef();
    l3_undef_prio = 1; l3_fp_trap = 1; l2_fp_trap = 1;
    access("R6 priority undef beats level-2 trap", 2'd1, UND, 8'h00);
    l3_undef_prio = 1;
    access("R6 priority flag alone", 2'd1, OK, 8'h00);
    l1_cp_acc = 2'b00; l2_id3_trap = 1;
    access("R6 access field 00", 2'd1, UND, 8'h00);
    ns_cp_deny = 1; l2_is32 = 1; l2_cp_trap = 1;
    access("R6 non-secure deny", 2'd1, UND, 8'h00);
  endtask

  task automatic t_l1_l2_64();
    l2_fp_trap = 1; l2_id3_trap = 1;
    access("R7 level-2 FP trap", 2'd1, T64, 8'h07);
    l2_fp_trap = 1; l2_is32 = 1;
    access("R7 FP trap ignored for 32-bit level 2", 2'd1, OK, 8'h00);
    l2_fp_trap = 1; l2_host = 1;
    access("R7 FP trap ignored in host mode", 2'd1, OK, 8'h00);
    l2_host = 1; l2_host_fp_en0 = 0;
    access("R7 host FP enable low", 2'd1, T64, 8'h07);
  endtask

  task automatic t_l1_hyp();
    l2_is32 = 1; l2_cp_trap = 1;
    access("R8 32-bit coprocessor trap", 2'd1, T32, 8'h08);
    l2_is32 = 1; l2_id3_trap = 1;
    access("R8 ID trap 32-bit", 2'd1, T32, 8'h08);
    l2_id3_trap = 1; l3_fp_trap = 1;
    access("R8 ID trap 64-bit beats level-3", 2'd1, T64, 8'h08);
    l2_en = 0; l2_id3_trap = 1; l2_cp_trap = 1; l2_is32 = 1;
    access("R8 level 2 disabled", 2'd1, OK, 8'h00);
  endtask

  task automatic t_l3_trap();
    l3_fp_trap = 1;
    access("R9 level-3 trap from 1", 2'd1, T3, 8'h07);
    l3_fp_trap = 1; l3_undef_ovr = 1;
    access("R9 override gives undef", 2'd1, UND, 8'h00);
    l3_fp_trap = 1; l3_is32 = 1;
    access("R9 32-bit level 3 ignored", 2'd1, OK, 8'h00);
    l3_fp_trap = 1;
    access("R9 level-3 trap from 2", 2'd2, T3, 8'h07);
    l3_fp_trap = 1; l3_present = 0;
    access("R9 no level 3", 2'd2, OK, 8'h00);
  endtask

  task automatic t_l2();
    l2_id3_trap = 1; l1_cp_acc = 2'b00;
    access("R10 ID trap and access field ignored", 2'd2, OK, 8'h00);
    l2_is32 = 1; l2_cp_trap = 1;
    access("R10 coprocessor trap code 00", 2'd2, T32, 8'h00);
    ns_cp_deny = 1; l3_fp_trap = 1;
    access("R10 non-secure deny code 00", 2'd2, T32, 8'h00);
    l2_host = 1; l2_host_fp_en0 = 0; l2_cp_trap = 1;
    access("R10 host enable beats coprocessor trap", 2'd2, T64, 8'h07);
    l3_undef_prio = 1; l3_fp_trap = 1; l2_host = 1; l2_host_fp_en0 = 0;
    access("R10 priority undef first", 2'd2, UND, 8'h00);
  endtask

  task automatic t_l3();
    l1_cp_acc = 2'b00;
    access("R11 access field 00", 2'd3, UND, 8'h00);
    l1_cp_acc = 2'b01; l3_fp_trap = 1; l3_undef_prio = 1; l2_id3_trap = 1;
    l2_host = 1; l2_host_fp_en0 = 0; ns_cp_deny = 1; l2_cp_trap = 1;
    access("R11 other controls ignored", 2'd3, OK, 8'h00);
  endtask

  task automatic t_value();
    @(negedge clk);
    cur_lvl = 2'd3; req_vld = 1;
    @(negedge clk);
    req_vld = 0;
    check("R12 field order", {14'h0, rsp_data}, {14'h0, 32'h1210_1101});
    check("R13 legal half-precision pair", {38'h0, rsp_data[27:20]}, {38'h0, 8'h21});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    benign();
    repeat (3) @(negedge clk);
    t_reset();
    t_timing();
    t_no_aa32();
    t_lvl0();
    t_write();
    t_l1_undef();
    t_l1_l2_64();
    t_l1_hyp();
    t_l3_trap();
    t_l2();
    t_l3();
    t_value();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule